// File: doc/BRIEF.md
# Direct-Mapped Row-Cache DRAM Command Scheduler

This block sits on the controller side of a DRAM whose sense amplifiers also act as a small row cache. Each physical bank keeps a few cached row entries. The low bits of a row address pick exactly one entry in the bank. The scheduler accepts read and write requests, each carrying a bank and a row. The requests pass through a short queue. The block keeps the valid flag and row tag of every entry, and from these it decides whether a read can be served straight from the cache with its bank closed.

It drives one DRAM command per cycle on a valid/opcode/bank/row interface. A read hit produces a lone column read. A read miss opens the row, reads it (which also loads it into the entry), and closes the bank again. Every write opens the row, writes it through to the array and to the entry, and closes the bank, so no entry ever holds data that the array lacks. A refresh request produces an auto-refresh command between operations. During the refresh window activates are held off, but read hits keep flowing.

Top module: `cdram_sched`

## Requirements
- R1: After reset every cache entry is invalid, no command is issued, and `req_ready` is high; the first read of any row is therefore a miss.
- R2: A read miss produces ACT, then RD exactly T_RCD cycles after the ACT, then PRE in the next cycle, all carrying the request's bank and row; it leaves the row cached.
- R3: A read to a row held in its entry produces a single RD with no ACT or PRE.
- R4: The entry is selected by the row's low log2(LINES) bits and the remaining bits form the tag; a fill replaces whatever that entry held, while rows with different low bits coexist in the same bank.
- R5: Every write, hit or not, produces ACT, WR T_RCD cycles later, then PRE, and leaves the written row cached.
- R6: A refresh request that arrives while an operation is under way produces REF only after that operation's PRE, in the cycle right after it; when the scheduler is idle, a pending refresh is issued ahead of queued requests.
- R7: For T_RFC cycles after REF, no ACT is issued; read hits are still served in that window, and a stalled miss gets its ACT in the first cycle after the window.
- R8: The request queue holds QDEPTH entries; `req_ready` falls when it is full, and requests are carried out in arrival order.
- R9: Opcode encoding is NOP=0, ACT=1, RD=2, WR=3, PRE=4, REF=5; `cmd_valid` is high only with a non-NOP opcode; REF carries bank 0 and row 0; no command is issued that a request or refresh did not call for.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue has room; request accepted when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| ref_req | input | 1 | One-cycle pulse asking for an auto refresh |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_op | output | 3 | Command opcode (see R9) |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Command row |

## Verification
The bench builds the block with a 4-bit row, 4 banks of 4 entries, a queue of 3, T_RCD of 2 and T_RFC of 8. With these values each entry has only four possible tags, so a full sweep over every bank and row reaches each fill, hit and eviction, and a reference model of the tag array predicts every command. The short refresh window lets the bench fill the queue behind a blocked activate, serve a hit inside the window, and time the first activate after it to the exact cycle.

// File: rtl/cdram_pkg.sv
// Shared types for the row-cache DRAM scheduler.
// Assumes: opcode values are fixed and decoded by the DRAM command driver.
package cdram_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } cdram_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_COL,
        ST_PRE
    } cdram_state_e;

endpackage

// File: rtl/cdram_req_fifo.sv
// Small request queue in front of the scheduler.
// Holds DEPTH entries of W bits; DEPTH need not be a power of two.
// Assumes: the writer never pushes when full and the reader never pops when empty.
module cdram_req_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    // Next slot index with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store an accepted request.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Advance pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign dout  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop)); // R8
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R8
endmodule

// File: rtl/cdram_row_tags.sv
// Valid flags and row tags for the direct-mapped row cache.
// One entry per (bank, low row bits); the remaining row bits are the tag.
// Lookup is combinational with a single comparator; a fill writes one entry.
// Assumes: LINES is a power of two, at least 2.
module cdram_row_tags #(
    parameter int BANKS  = 4,
    parameter int LINES  = 4,
    parameter int ROW_W  = 13,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic [ROW_W-1:0]  lk_row,
    output logic              hit,
    input  logic              fill_en,
    input  logic [BANK_W-1:0] fill_bank,
    input  logic [ROW_W-1:0]  fill_row
);
    localparam int LINE_W = $clog2(LINES);
    localparam int TAG_W  = ROW_W - LINE_W;

    logic [BANKS-1:0][LINES-1:0] valid_q;
    logic [TAG_W-1:0]            tag_q [BANKS][LINES];

    logic [LINE_W-1:0] lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic [LINE_W-1:0] fill_idx;
    logic [TAG_W-1:0]  fill_tag;

    assign lk_idx   = lk_row[LINE_W-1:0];
    assign lk_tag   = lk_row[ROW_W-1:LINE_W];
    assign fill_idx = fill_row[LINE_W-1:0];
    assign fill_tag = fill_row[ROW_W-1:LINE_W];

    // Valid flags: cleared on reset, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n)       valid_q <= '0;
        else if (fill_en) valid_q[fill_bank][fill_idx] <= 1'b1;
    end

    // Row tags: overwritten by a fill, never reset (guarded by valid).
    always_ff @(posedge clk) begin
        if (fill_en) tag_q[fill_bank][fill_idx] <= fill_tag;
    end

    assign hit = valid_q[lk_bank][lk_idx] && (tag_q[lk_bank][lk_idx] == lk_tag);

    // Record the last fill address for the check below.
    logic [BANK_W-1:0] chk_bank;
    logic [LINE_W-1:0] chk_idx;
    logic [TAG_W-1:0]  chk_tag;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_bank <= '0;
            chk_idx  <= '0;
            chk_tag  <= '0;
        end else if (fill_en) begin
            chk_bank <= fill_bank;
            chk_idx  <= fill_idx;
            chk_tag  <= fill_tag;
        end
    end

    AST_FILL_TAKES_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (valid_q[chk_bank][chk_idx] && tag_q[chk_bank][chk_idx] == chk_tag)); // R4
endmodule

// File: rtl/cdram_ref_guard.sv
// Refresh request latch and refresh-window timer.
// A ref_req pulse sets a pending flag; issuing REF clears it and starts a
// T_RFC-cycle window during which ref_busy is high.
// Assumes: the scheduler issues REF only while pending and not busy.
module cdram_ref_guard #(
    parameter int T_RFC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_req,
    input  logic issue,
    output logic ref_pend,
    output logic ref_busy
);
    localparam int CW = $clog2(T_RFC + 1);

    logic          pend_q;
    logic [CW-1:0] cnt_q;

    // Pending flag and window countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            pend_q <= ref_req | (pend_q & ~issue);
            if (issue)             cnt_q <= CW'(T_RFC);
            else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
        end
    end

    assign ref_pend = pend_q;
    assign ref_busy = (cnt_q != '0);

    AST_REF_ONLY_WHEN_ASKED: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (pend_q && !ref_busy)); // R6
    AST_REF_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> ref_busy); // R7
endmodule

// File: rtl/cdram_sched.sv
// Command scheduler for a DRAM whose sense amplifiers serve as a row cache.
// Read hits go out as a lone RD with the bank closed; read misses and all
// writes run ACT / column / PRE and fill the direct-mapped entry at ACT.
// Refresh goes out between operations; while its window runs, activates
// are held but read hits continue.
// Assumes: T_RCD >= 1, T_RFC >= 1, LINES a power of two.
module cdram_sched
    import cdram_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int LINES  = 4,
    parameter int ROW_W  = 13,
    parameter int QDEPTH = 3,
    parameter int T_RCD  = 2,
    parameter int T_RFC  = 8,
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic              ref_req,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row
);
    localparam int REQ_W = 1 + BANK_W + ROW_W;
    localparam int WCW   = $clog2(T_RCD + 1);

    logic              q_empty;
    logic              q_full;
    logic              q_pop;
    logic [REQ_W-1:0]  q_head;
    logic              h_write;
    logic [BANK_W-1:0] h_bank;
    logic [ROW_W-1:0]  h_row;
    logic              hit;
    logic              fill_en;
    logic              ref_issue;
    logic              ref_pend;
    logic              ref_busy;

    cdram_state_e      state_q, state_d;
    logic [WCW-1:0]    wait_q, wait_d;
    logic              cur_write;
    logic [BANK_W-1:0] cur_bank;
    logic [ROW_W-1:0]  cur_row;

    cdram_cmd_e        op_d;
    logic              valid_d;
    logic [BANK_W-1:0] bank_d;
    logic [ROW_W-1:0]  row_d;

    assign req_ready = !q_full;

    cdram_req_fifo #(
        .W     (REQ_W),
        .DEPTH (QDEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (req_valid && !q_full),
        .din   ({req_write, req_bank, req_row}),
        .pop   (q_pop),
        .dout  (q_head),
        .empty (q_empty),
        .full  (q_full)
    );

    assign {h_write, h_bank, h_row} = q_head;

    cdram_row_tags #(
        .BANKS  (BANKS),
        .LINES  (LINES),
        .ROW_W  (ROW_W),
        .BANK_W (BANK_W)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_bank   (h_bank),
        .lk_row    (h_row),
        .hit       (hit),
        .fill_en   (fill_en),
        .fill_bank (h_bank),
        .fill_row  (h_row)
    );

    cdram_ref_guard #(
        .T_RFC (T_RFC)
    ) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_req  (ref_req),
        .issue    (ref_issue),
        .ref_pend (ref_pend),
        .ref_busy (ref_busy)
    );

    // Operation state, activate-to-column countdown and the open request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            wait_q    <= '0;
            cur_write <= 1'b0;
            cur_bank  <= '0;
            cur_row   <= '0;
        end else begin
            state_q <= state_d;
            wait_q  <= wait_d;
            if (fill_en) begin
                cur_write <= h_write;
                cur_bank  <= h_bank;
                cur_row   <= h_row;
            end
        end
    end

    // Pick this cycle's command and the next state.
    always_comb begin
        state_d   = state_q;
        wait_d    = wait_q;
        op_d      = CMD_NOP;
        valid_d   = 1'b0;
        bank_d    = cur_bank;
        row_d     = cur_row;
        q_pop     = 1'b0;
        fill_en   = 1'b0;
        ref_issue = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_pend && !ref_busy) begin
                    op_d      = CMD_REF;
                    valid_d   = 1'b1;
                    ref_issue = 1'b1;
                    bank_d    = '0;
                    row_d     = '0;
                end else if (!q_empty) begin
                    if (!h_write && hit) begin
                        op_d    = CMD_RD;
                        valid_d = 1'b1;
                        bank_d  = h_bank;
                        row_d   = h_row;
                        q_pop   = 1'b1;
                    end else if (!ref_busy) begin
                        op_d    = CMD_ACT;
                        valid_d = 1'b1;
                        bank_d  = h_bank;
                        row_d   = h_row;
                        fill_en = 1'b1;
                        if (T_RCD > 1) begin
                            state_d = ST_WAIT;
                            wait_d  = WCW'(T_RCD - 1);
                        end else begin
                            state_d = ST_COL;
                        end
                    end
                end
            end
            ST_WAIT: begin
                if (wait_q <= WCW'(1)) state_d = ST_COL;
                else                   wait_d  = wait_q - 1'b1;
            end
            ST_COL: begin
                op_d    = cur_write ? CMD_WR : CMD_RD;
                valid_d = 1'b1;
                q_pop   = 1'b1;
                state_d = ST_PRE;
            end
            ST_PRE: begin
                op_d    = CMD_PRE;
                valid_d = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign cmd_valid = valid_d;
    assign cmd_op    = op_d;
    assign cmd_bank  = bank_d;
    assign cmd_row   = row_d;

    AST_NO_ACT_IN_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == CMD_ACT) |-> !ref_busy); // R7
    AST_PRE_AFTER_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == CMD_PRE) |->
            ($past(cmd_valid) && ($past(cmd_op) == CMD_RD || $past(cmd_op) == CMD_WR))); // R2
    AST_VALID_MEANS_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_op != CMD_NOP)); // R9
endmodule

// File: tb/cdram_sched_bench.sv
module cdram_sched_bench;
    localparam int ROW_W = 4;
    localparam int T_RCD = 2;
    localparam int T_RFC = 8;
    localparam int OP_ACT = 1, OP_RD = 2, OP_WR = 3, OP_PRE = 4, OP_REF = 5;
    localparam int EXP_N = 8192;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_write = 1'b0;
    logic [1:0]       req_bank = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic             ref_req = 1'b0;
    logic             cmd_valid;
    logic [2:0]       cmd_op;
    logic [1:0]       cmd_bank;
    logic [ROW_W-1:0] cmd_row;

    always #5 clk = ~clk;

    cdram_sched #(
        .BANKS (4), .LINES (4), .ROW_W (ROW_W),
        .QDEPTH (3), .T_RCD (T_RCD), .T_RFC (T_RFC)
    ) u_cdram_sched (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_write (req_write), .req_bank (req_bank), .req_row (req_row),
        .ref_req (ref_req),
        .cmd_valid (cmd_valid), .cmd_op (cmd_op),
        .cmd_bank (cmd_bank), .cmd_row (cmd_row)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Expected command stream built by the tag model.
    int    exp_op   [EXP_N];
    int    exp_bank [EXP_N];
    int    exp_row  [EXP_N];
    string exp_tag  [EXP_N];
    int    exp_wr = 0;
    int    exp_rd = 0;

    // Reference tag state.
    bit m_valid [4][4];
    int m_tag   [4][4];

    // Timing records from the monitor.
    int last_act_cyc = -100;
    int last_col_cyc = -100;
    int last_pre_cyc = -100;
    int ref_cyc      = -1000;
    int ref_pre_gap  = -1;
    int ref_rd_cyc   = -1;
    int ref_act_cyc  = -1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic void add_exp(input int op, input int b, input int r, input string tg);
        exp_op[exp_wr]   = op;
        exp_bank[exp_wr] = b;
        exp_row[exp_wr]  = r;
        exp_tag[exp_wr]  = tg;
        exp_wr++;
    endfunction

    // Apply one request to the model and queue its expected commands.
    function automatic void model(input bit w, input int b, input int r,
                                  input string t_miss, input string t_hit);
        int idx = r % 4;
        int tg  = r / 4;
        if (!w && m_valid[b][idx] && m_tag[b][idx] == tg) begin
            add_exp(OP_RD, b, r, t_hit);
        end else begin
            add_exp(OP_ACT, b, r, t_miss);
            add_exp(w ? OP_WR : OP_RD, b, r, t_miss);
            add_exp(OP_PRE, b, r, t_miss);
            m_valid[b][idx] = 1'b1;
            m_tag[b][idx]   = tg;
        end
    endfunction

    task automatic send(input bit w, input int b, input int r,
                        input string t_miss, input string t_hit);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_bank  = b[1:0];
        req_row   = r[ROW_W-1:0];
        model(w, b, r, t_miss, t_hit);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain(input int extra);
        while (exp_rd != exp_wr) @(negedge clk);
        repeat (extra) @(negedge clk);
    endtask

    task automatic pulse_ref();
        ref_req = 1'b1;
        add_exp(OP_REF, 0, 0, "R6");
        @(negedge clk);
        ref_req = 1'b0;
    endtask

    // Monitor: compare every issued command with the model, in order.
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            if (exp_rd >= exp_wr) begin
                chk(1'b0, "R9", "unexpected command op", int'(cmd_op), 0);
            end else begin
                checks++;
                if (int'(cmd_op) != exp_op[exp_rd] || int'(cmd_bank) != exp_bank[exp_rd] ||
                    int'(cmd_row) != exp_row[exp_rd]) begin
                    errors++;
                    $display("FAIL %s command #%0d: actual op=%0d bank=%0d row=%0d expected op=%0d bank=%0d row=%0d",
                             exp_tag[exp_rd], exp_rd, cmd_op, cmd_bank, cmd_row,
                             exp_op[exp_rd], exp_bank[exp_rd], exp_row[exp_rd]);
                end
                if ((cmd_op == 3'(OP_RD) || cmd_op == 3'(OP_WR)) && exp_rd > 0 &&
                    exp_op[exp_rd-1] == OP_ACT) begin
                    chk(cyc - last_act_cyc == T_RCD, "R2", "ACT to column gap",
                        cyc - last_act_cyc, T_RCD);
                    last_col_cyc = cyc;
                end
                if (cmd_op == 3'(OP_PRE)) begin
                    chk(cyc - last_col_cyc == 1, "R2", "column to PRE gap", cyc - last_col_cyc, 1);
                    last_pre_cyc = cyc;
                end
                if (cmd_op == 3'(OP_ACT)) begin
                    chk(cyc > ref_cyc + T_RFC, "R7", "ACT inside refresh window", cyc, ref_cyc + T_RFC + 1);
                    last_act_cyc = cyc;
                    if (ref_act_cyc < 0) ref_act_cyc = cyc;
                end
                if (cmd_op == 3'(OP_RD) && ref_rd_cyc < 0) ref_rd_cyc = cyc;
                if (cmd_op == 3'(OP_REF)) begin
                    ref_cyc     = cyc;
                    ref_pre_gap = cyc - last_pre_cyc;
                    ref_rd_cyc  = -1;
                    ref_act_cyc = -1;
                end
                exp_rd++;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d commands", exp_rd, exp_wr);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned rng = 32'h1234_5678;
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 4; i++) begin
                m_valid[b][i] = 1'b0;
                m_tag[b][i]   = 0;
            end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(cmd_valid == 1'b0, "R1", "cmd_valid after reset", int'(cmd_valid), 0);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);

        // R1 R3 R4: sweep every bank and row, each read twice
        for (int b = 0; b < 4; b++)
            for (int r = 0; r < 16; r++) begin
                send(1'b0, b, r, (r < 4) ? "R1" : "R4", "R3");
                send(1'b0, b, r, "R2", "R3");
            end
        drain(2);

        // R4: rows with distinct low bits coexist; same low bits evict
        for (int b = 0; b < 4; b++) begin
            for (int r = 12; r < 16; r++) send(1'b0, b, r, "R4", "R4");
            send(1'b0, b, 0, "R4", "R4");
            send(1'b0, b, 13, "R4", "R4");
        end
        drain(2);

        // R5: writes always open the row and leave it cached
        send(1'b1, 2, 5, "R5", "R5");
        send(1'b0, 2, 5, "R5", "R5");
        send(1'b1, 2, 9, "R5", "R5");
        send(1'b0, 2, 5, "R5", "R5");
        send(1'b1, 2, 5, "R5", "R5");
        send(1'b1, 2, 5, "R5", "R5");
        send(1'b0, 2, 5, "R5", "R5");
        drain(T_RFC + 2);

        // R6: refresh asked during an operation waits for its PRE
        send(1'b1, 1, 6, "R6", "R6");
        pulse_ref();
        drain(T_RFC + 2);
        chk(ref_pre_gap == 1, "R6", "REF after PRE gap", ref_pre_gap, 1);

        // R7: hit served inside the window, miss activates right after it
        pulse_ref();
        send(1'b0, 0, 0, "R7", "R7");
        send(1'b0, 3, 5, "R7", "R7");
        drain(T_RFC + 2);
        chk(ref_rd_cyc >= 0 && ref_rd_cyc <= ref_cyc + T_RFC, "R7",
            "hit RD cycle within refresh window", ref_rd_cyc - ref_cyc, 1);
        chk(ref_act_cyc == ref_cyc + T_RFC + 1, "R7", "first ACT after refresh",
            ref_act_cyc - ref_cyc, T_RFC + 1);

        // R8: queue fills behind a blocked activate, then drains in order
        pulse_ref();
        send(1'b1, 0, 7, "R8", "R8");
        send(1'b1, 1, 7, "R8", "R8");
        send(1'b1, 2, 7, "R8", "R8");
        chk(req_ready == 1'b0, "R8", "req_ready with queue full", int'(req_ready), 0);
        send(1'b0, 3, 7, "R8", "R8");
        drain(T_RFC + 2);

        // R6 priority: pending refresh goes ahead of an already queued request
        ref_req = 1'b1;
        add_exp(OP_REF, 0, 0, "R6");
        send(1'b0, 0, 7, "R6", "R6");
        ref_req = 1'b0;
        drain(T_RFC + 2);

        // Random streams checked against the tag model
        for (int n = 0; n < 500; n++) begin
            bit w;
            int b;
            int r;
            rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
            w = (rng[1:0] == 2'd0);
            b = int'(rng[5:4]);
            r = int'(rng[11:8]);
            send(w, b, r, w ? "R5" : "R2", "R3");
            if (rng[15:14] == 2'd0) repeat (int'(rng[19:17])) @(negedge clk);
        end
        drain(4);

        // R9: nothing left outstanding, nothing extra issued
        chk(exp_rd == exp_wr, "R9", "commands issued", exp_rd, exp_wr);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule